// File: doc/BRIEF.md
# Host Read Sequencer for a Shared Single-Port RAM

This block lets an external microprocessor read from a single-port RAM that internal engines also use, and those engines always win. The host's chip-select and read strobe arrive asynchronously. They are combined and passed through a chain of flip-flops. A host access is accepted only when every stage of that chain shows the request, no internal engine is asking for the RAM, and the post-access holdoff window has run out.

After acceptance the sequencer samples one address bit to choose between a command-register read and a RAM read. For a RAM read it walks a fixed cycle pattern:
- It enables the external address buffer and the RAM.
- It drops the data-latch clock, then raises it to capture the RAM word.
- It releases the RAM and acknowledges the host.

The acknowledge is held until the host withdraws its request. Once the acknowledge drops, a holdoff window stalls the next host access. This spaces back-to-back host reads so that the internal engines get a turn.

The data-buffer enable follows the host strobes directly, with no clocking. The buffer direction stays toward the host, because this block only handles reads. A command-register read goes through the same number of cycles but never touches the RAM controls. Instead it returns a captured register word together with the acknowledge.

Top module: `hostReadSeq`

## Requirements
- R1: While `rstN` is low, every active-low control output (`addrBufEnN`, `ramCsN`, `ramOeN`, `hostAckN`) is high, `latchClk` is high, and `holdoff` and `regDataOe` are low.
- R2: `dataBufEnN` is low exactly when `hostCsN` and `hostRdN` are both low, with no clock involved.
- R3: `bufDir` is always high, so the data buffer points toward the host.
- R4: The host request (`hostCsN` and `hostRdN` both low) is accepted only at a rising edge where it was present at each of the two preceding rising edges. With a request applied just after edge 0, acceptance is at edge 3. `hostRegSel` is sampled at the accepting edge: 0 selects a RAM read and 1 selects a command-register read.
- R5: For a RAM read, `addrBufEnN` and `latchClk` are low from the accepting edge until the second edge after it. At that edge `addrBufEnN` returns high and `latchClk` rises.
- R6: For a RAM read, `ramOeN` and `ramCsN` are low from the accepting edge until the third edge after it, and go high there unless an internal request holds `ramCsN` low.
- R7: `hostAckN` falls at the third edge after acceptance, which is the sixth edge after the request appears. It rises at the second edge after the host withdraws its request.
- R8: No access is accepted at an edge where `intReq` is high or `holdoff` is high.
- R9: `holdoff` rises at the edge where `hostAckN` rises and stays high for `HOLD_CYCLES` cycles. With the default of 24, a host that re-requests at once sees 28 cycles between acknowledges.
- R10: For a command-register read, the RAM, address-buffer and latch outputs stay idle. `cmdRegData` is captured at the edge where `hostAckN` falls. `regDataOut` shows it while `regDataOe` is high together with the acknowledge, and is zero otherwise.
- R11: `ramCsN` follows `intReq` one edge later. When an internal access hands the RAM straight to an accepted host RAM read, `ramCsN` stays low with no high cycle in between.
- R12: A request seen at only one rising edge is never accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip-select, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostRegSel | input | 1 | Address bit: 1 = command register, 0 = RAM |
| intReq | input | 1 | An internal engine wants the RAM |
| cmdRegData | input | DATA_W | Command register contents |
| dataBufEnN | output | 1 | External data-buffer enable, active low |
| addrBufEnN | output | 1 | External address-buffer enable, active low |
| bufDir | output | 1 | Data-buffer direction, high = toward host |
| latchClk | output | 1 | Data-latch clock; rising edge captures RAM data |
| ramCsN | output | 1 | RAM chip-select, active low |
| ramOeN | output | 1 | RAM output-enable, active low |
| hostAckN | output | 1 | Host acknowledge, active low |
| holdoff | output | 1 | High while the next host access is stalled |
| regDataOut | output | DATA_W | Command register word for the host |
| regDataOe | output | 1 | regDataOut is valid |

## Verification
The bench builds the block with its defaults: a 16-bit data width, two synchronizer stages and a 24-cycle holdoff. With these values the gap between back-to-back acknowledges lands at 28 cycles, and the six-edge request-to-acknowledge latency can be observed directly. The stimulus covers the following cases:
- A one-edge request pulse.
- A request held while an internal engine owns the RAM, followed by a chip-select handover with no gap.
- A command-register read.
- A host that re-requests while the holdoff is still running.

// File: rtl/hostReadPkg.sv
package hostReadPkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_LATCH  = 3'd3,
    ST_ACK    = 3'd4
  } seqState_e;

  // Strobes from the control FSM into the datapath. The phase flags
  // describe the state being entered so that the datapath can
  // register clean, glitch-free outputs.
  typedef struct packed {
    logic start;      // request accepted at this edge
    logic capture;    // acknowledge phase entered at this edge
    logic finish;     // acknowledge phase left at this edge
    logic ramPhase;   // next cycle owns the RAM for the host
    logic addrPhase;  // next cycle drives the address buffer
    logic ackPhase;   // next cycle acknowledges the host
    logic regRead;    // current transfer targets the command register
  } seqStrobe_t;

endpackage

// File: rtl/hostReadCtrl.sv
module hostReadCtrl
  import hostReadPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSeen,
  input  logic       reqNewest,
  input  logic       intReq,
  input  logic       holdoff,
  input  logic       hostRegSel,
  output seqStrobe_t str
);

  seqState_e state, nextState;
  logic      selQ, selNext;
  logic      grant;

  assign grant = reqSeen && !intReq && !holdoff;

  always_comb begin
    nextState = state;
    selNext   = selQ;
    unique case (state)
      ST_IDLE: begin
        if (grant) begin
          nextState = ST_ADDR;
          selNext   = hostRegSel;
        end
      end
      ST_ADDR:   nextState = ST_SETTLE;
      ST_SETTLE: nextState = ST_LATCH;
      ST_LATCH:  nextState = ST_ACK;
      ST_ACK: begin
        if (!reqNewest) nextState = ST_IDLE;
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selQ  <= 1'b0;
    end else begin
      state <= nextState;
      selQ  <= selNext;
    end
  end

  logic nextInRam, nextInAddr;
  assign nextInRam  = (nextState == ST_ADDR) || (nextState == ST_SETTLE) ||
                      (nextState == ST_LATCH);
  assign nextInAddr = (nextState == ST_ADDR) || (nextState == ST_SETTLE);

  always_comb begin
    str.start     = (state == ST_IDLE) && (nextState == ST_ADDR);
    str.capture   = (state == ST_LATCH);
    str.finish    = (state == ST_ACK) && (nextState == ST_IDLE);
    str.ramPhase  = nextInRam && !selNext;
    str.addrPhase = nextInAddr && !selNext;
    str.ackPhase  = (nextState == ST_ACK);
    str.regRead   = selNext;
  end

  // R8: a pending holdoff or internal request keeps the sequencer idle
  p_blocked_stays_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && (holdoff || intReq)) |=> (state == ST_IDLE));

  // R4: entering the address phase requires a fully synchronized request
  p_start_needs_sync_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ADDR) |-> $past(reqSeen));

  // R7: the acknowledge phase is always entered from the latch phase
  p_ack_after_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ACK) |-> $past(state) == ST_LATCH);

endmodule

// File: rtl/hostReadPath.sv
module hostReadPath
  import hostReadPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HOLD_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              intReq,
  input  logic [DATA_W-1:0] cmdRegData,
  input  seqStrobe_t        str,
  output logic              reqSeen,
  output logic              reqNewest,
  output logic              holdoff,
  output logic              addrBufEnN,
  output logic              latchClk,
  output logic              ramCsN,
  output logic              ramOeN,
  output logic              hostAckN,
  output logic [DATA_W-1:0] regDataOut,
  output logic              regDataOe
);

  localparam int CNT_W = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

  // Request synchronizer: every stage must show the request
  logic [SYNC_STAGES-1:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= hostReq;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign reqNewest = syncQ[0];
  assign reqSeen   = &syncQ;

  // Holdoff window between host accesses
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (str.finish)      holdCnt <= HOLD_LOAD;
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign holdoff = (holdCnt != '0);

  // Registered interface controls
  logic              regDataOeQ;
  logic [DATA_W-1:0] regDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrBufEnN <= 1'b1;
      latchClk   <= 1'b1;
      ramOeN     <= 1'b1;
      ramCsN     <= 1'b1;
      hostAckN   <= 1'b1;
      regDataOeQ <= 1'b0;
    end else begin
      addrBufEnN <= ~str.addrPhase;
      latchClk   <= ~str.addrPhase;
      ramOeN     <= ~str.ramPhase;
      ramCsN     <= ~(str.ramPhase | intReq);
      hostAckN   <= ~str.ackPhase;
      regDataOeQ <= str.ackPhase & str.regRead;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          regDataQ <= '0;
    else if (str.capture && str.regRead) regDataQ <= cmdRegData;
  end

  assign regDataOe  = regDataOeQ;
  assign regDataOut = regDataOeQ ? regDataQ : '0;

  // R5: the latch edge comes after the address buffer is released
  p_latch_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchClk) |-> (addrBufEnN && !ramOeN));

  // R5: the address buffer is only enabled while the RAM drives data
  p_addr_with_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !addrBufEnN |-> !ramOeN);

  // R6: the RAM is released before the host sees the acknowledge
  p_ack_ram_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hostAckN |-> ramOeN);

  // R6: a low latch clock implies the RAM is selected
  p_latch_with_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    !latchClk |-> !ramCsN);

  // R9: ending an acknowledge always opens the holdoff window
  p_holdoff_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAckN) |-> holdoff);

endmodule

// File: rtl/hostReadSeq.sv
module hostReadSeq
  import hostReadPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HOLD_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostRegSel,
  input  logic              intReq,
  input  logic [DATA_W-1:0] cmdRegData,
  output logic              dataBufEnN,
  output logic              addrBufEnN,
  output logic              bufDir,
  output logic              latchClk,
  output logic              ramCsN,
  output logic              ramOeN,
  output logic              hostAckN,
  output logic              holdoff,
  output logic [DATA_W-1:0] regDataOut,
  output logic              regDataOe
);

  seqStrobe_t str;
  logic       reqSeen, reqNewest;
  logic       hostReq;

  assign hostReq    = ~hostCsN & ~hostRdN;
  assign dataBufEnN = ~hostReq;
  assign bufDir     = 1'b1;

  hostReadCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqSeen    (reqSeen),
    .reqNewest  (reqNewest),
    .intReq     (intReq),
    .holdoff    (holdoff),
    .hostRegSel (hostRegSel),
    .str        (str)
  );

  hostReadPath #(
    .DATA_W      (DATA_W),
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .intReq     (intReq),
    .cmdRegData (cmdRegData),
    .str        (str),
    .reqSeen    (reqSeen),
    .reqNewest  (reqNewest),
    .holdoff    (holdoff),
    .addrBufEnN (addrBufEnN),
    .latchClk   (latchClk),
    .ramCsN     (ramCsN),
    .ramOeN     (ramOeN),
    .hostAckN   (hostAckN),
    .regDataOut (regDataOut),
    .regDataOe  (regDataOe)
  );

  // R2: the data buffer enable tracks the raw host strobes
  p_databuf_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    !hostAckN |-> (dataBufEnN == (hostCsN | hostRdN)));

endmodule

// File: tb/hostReadSeq_bench.sv
module hostReadSeq_bench;

  localparam int DW   = 16;
  localparam int HOLD = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic          hostCsN, hostRdN, hostRegSel, intReq;
  logic [DW-1:0] cmdRegData;
  logic          dataBufEnN, addrBufEnN, bufDir, latchClk;
  logic          ramCsN, ramOeN, hostAckN, holdoff, regDataOe;
  logic [DW-1:0] regDataOut;

  always #10 clk = ~clk;

  hostReadSeq #(.DATA_W(DW), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_hostReadSeq (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostRegSel(hostRegSel), .intReq(intReq), .cmdRegData(cmdRegData),
    .dataBufEnN(dataBufEnN), .addrBufEnN(addrBufEnN), .bufDir(bufDir),
    .latchClk(latchClk), .ramCsN(ramCsN), .ramOeN(ramOeN),
    .hostAckN(hostAckN), .holdoff(holdoff), .regDataOut(regDataOut),
    .regDataOe(regDataOe)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 3..5 access cycles, 6 acknowledge
  int          mS0, mS1, mPh, mHold;
  bit          mSel, mCs;
  logic [DW-1:0] mReg;

  always @(posedge clk) begin : model
    int nPh;
    bit nSel;
    bit req;
    if (!rstN) begin
      mS0 = 0; mS1 = 0; mPh = 0; mHold = 0; mSel = 0; mCs = 0; mReg = '0;
    end else begin
      req  = !hostCsN && !hostRdN;
      nPh  = mPh;
      nSel = mSel;
      if (mPh == 0) begin
        if (mS0 != 0 && mS1 != 0 && !intReq && mHold == 0) begin
          nPh = 3; nSel = hostRegSel;
        end
      end else if (mPh == 6) begin
        if (mS0 == 0) nPh = 0;
      end else begin
        nPh = mPh + 1;
      end
      if (mPh == 5 && nSel) mReg = cmdRegData;
      if (mPh == 6 && nPh == 0) mHold = HOLD;
      else if (mHold > 0)       mHold--;
      mCs = intReq || (!nSel && nPh >= 3 && nPh <= 5);
      mS1 = mS0; mS0 = req ? 1 : 0; mPh = nPh; mSel = nSel;
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit ramRd, addrPh;
    if (!done) begin
      ramRd  = !mSel && mPh >= 3 && mPh <= 5;
      addrPh = !mSel && (mPh == 3 || mPh == 4);
      chk("R2", "dataBufEnN", dataBufEnN, hostCsN | hostRdN);
      chk("R3", "bufDir", bufDir, 1'b1);
      if (!rstN) begin
        chk("R1", "addrBufEnN", addrBufEnN, 1'b1);
        chk("R1", "latchClk", latchClk, 1'b1);
        chk("R1", "ramCsN", ramCsN, 1'b1);
        chk("R1", "ramOeN", ramOeN, 1'b1);
        chk("R1", "hostAckN", hostAckN, 1'b1);
        chk("R1", "holdoff", holdoff, 1'b0);
        chk("R1", "regDataOe", regDataOe, 1'b0);
      end else begin
        chk("R5", "addrBufEnN", addrBufEnN, !addrPh);
        chk("R5", "latchClk", latchClk, !addrPh);
        chk("R6", "ramOeN", ramOeN, !ramRd);
        chk("R11", "ramCsN", ramCsN, !mCs);
        chk("R7", "hostAckN", hostAckN, mPh != 6);
        chk("R9", "holdoff", holdoff, mHold != 0);
        chk("R10", "regDataOe", regDataOe, mPh == 6 && mSel);
        chk("R10", "regDataOut", regDataOut, (mPh == 6 && mSel) ? mReg : '0);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<50000 cycles", cyc);
      finishRun();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic request(bit on);
    hostCsN = !on;
    hostRdN = !on;
  endtask

  initial begin
    int n;
    rstN = 1'b0; hostCsN = 1'b1; hostRdN = 1'b1; hostRegSel = 1'b0;
    intReq = 1'b0; cmdRegData = 16'h1234;
    step(3);
    rstN = 1'b1;
    step(3);

    // R4 R7: six edges from request to acknowledge for a RAM read
    request(1);
    n = 0;
    do begin @(negedge clk); n++; end while (hostAckN && n < 20);
    chk("R4", "latency", n, 6);
    // R7/R9: re-request at once, measure the gap between acknowledges
    #1 request(0);
    step(1);
    request(1);
    n = 0;
    do begin @(negedge clk); end while (!hostAckN);
    do begin @(negedge clk); n++; end while (hostAckN && n < 60);
    chk("R9", "ackGap", n, HOLD + 4);
    #1 request(0);
    n = 0;
    do begin @(negedge clk); end while (!holdoff);
    do begin @(negedge clk); n++; end while (holdoff && n < 60);
    chk("R9", "holdoffLen", n, HOLD);
    step(4);

    // R12: a request present at only one edge is ignored
    request(1);
    step(1);
    request(0);
    n = 0;
    repeat (12) begin @(negedge clk); if (!hostAckN || !ramOeN) n++; end
    chk("R12", "pulseIgnored", n, 0);
    step(2);

    // R10: command register read
    cmdRegData = 16'hA5C3;
    hostRegSel = 1'b1;
    request(1);
    n = 0;
    do begin @(negedge clk); n++; if (!ramOeN || !addrBufEnN) chk("R10", "ramIdle", 1, 0); end
      while (hostAckN && n < 20);
    chk("R10", "regData", regDataOut, 16'hA5C3);
    #1 request(0);
    hostRegSel = 1'b0;
    step(HOLD + 6);

    // R8 R11: internal owner blocks the host, then hands over with no gap
    intReq = 1'b1;
    step(2);
    request(1);
    step(6);
    chk("R8", "blockedAck", hostAckN, 1'b1);
    chk("R11", "csHeldByInt", ramCsN, 1'b0);
    intReq = 1'b0;
    n = 0;
    repeat (3) begin @(negedge clk); if (ramCsN) n++; end
    chk("R11", "csNoGap", n, 0);
    do begin @(negedge clk); end while (hostAckN);
    #1 request(0);
    step(HOLD + 6);

    // R8: an internal request arriving during holdoff extends the stall
    request(1);
    do begin @(negedge clk); end while (hostAckN);
    #1 request(0);
    step(3);
    intReq = 1'b1;
    request(1);
    step(HOLD + 4);
    chk("R8", "stillBlocked", hostAckN, 1'b1);
    intReq = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (hostAckN && n < 20);
    chk("R7", "ackAfterRelease", n, 4);
    #1 request(0);
    step(HOLD + 4);

    finishRun();
  end

endmodule